// File: doc/BRIEF.md
# Privileged-Mode Trap Entry Controller

This block decides, once per clock, whether the processor leaves normal execution for its privileged code region. A synchronous exception, presented with a code, is always a candidate. Four asynchronous interrupt request lines are candidates only under two conditions: the processor is outside privileged mode, and the line's level clears the current interrupt priority level (IPL). When an entry happens, the block computes the byte offset of the handler inside the privileged region. It adds that offset to the region base register to form the new program counter. It also records the interrupted PC, tagging bit 0 with the mode the processor was in, and sets the privileged-mode flag.

The inputs and outputs are control-level and carry no handshake. Each candidate is sampled on a rising edge. The resulting state is held in output registers until the next entry, and a one-cycle `taken` pulse marks each update. No back-pressure applies: the surrounding pipeline presents a new PC and mode on every cycle and consumes the outputs whenever `taken` is high. An exception with an undefined code produces a one-cycle `code_err` pulse in place of an entry.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `priv_in` is 1, no interrupt request causes an entry. Exceptions are still taken.
- R2: IPL masking. Device (`irq_req[0]`) is eligible when IPL ≤ 3. Timer (`irq_req[1]`) is eligible when IPL ≤ 4. Interprocessor (`irq_req[2]`) is eligible when IPL ≤ 5. Machine check (`irq_req[3]`) is eligible when IPL ≤ 6. IPL 7 masks all four.
- R3: Among eligible requests the winner is, from highest to lowest: machine check, interprocessor, timer, device. The handler offsets are 0x080, 0x100, 0x180 and 0x200 respectively.
- R4: Exception codes 0 to 9 (reset, machine check, interprocessor, timer, device, memory fault, unaligned, illegal opcode, arithmetic, FP disabled) enter at offset code×0x80, so 0x000 to 0x480.
- R5: Exception code 10 is a privileged call with call code c. Its offset is 0x2000 + (c − 0x80)×64 when c[7] = 1, and 0x1000 + c×64 otherwise.
- R6: On entry, `exc_addr` equals `pc_in` with bit 0 replaced by (`pc_in[0]` OR `priv_in`).
- R7: On entry, `new_pc` = `pal_base` + offset and `priv_out` = 1. These update on the same edge as a one-cycle `taken` pulse, one cycle after the inputs are sampled. Without an entry, all three registers hold their values.
- R8: A valid exception takes precedence over any pending interrupt in the same cycle.
- R9: An exception with code 11 to 15 pulses `code_err` for one cycle. No entry happens that cycle, and no interrupt is accepted in it.
- R10: After reset, `new_pc`, `exc_addr`, `priv_out`, `taken` and `code_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 4 | Interrupt requests: [0] device, [1] timer, [2] interprocessor, [3] machine check |
| exc_valid | input | 1 | A synchronous exception is presented this cycle |
| exc_code | input | 4 | Exception code (0–10 defined) |
| call_code | input | 8 | Privileged-call code, used with exception code 10 |
| pc_in | input | 64 | Current program counter |
| pal_base | input | 64 | Privileged region base address |
| ipl | input | 3 | Current interrupt priority level |
| priv_in | input | 1 | Current privileged-mode flag |
| new_pc | output | 64 | Handler program counter, held between entries |
| exc_addr | output | 64 | Saved return address with mode tag in bit 0 |
| priv_out | output | 1 | Updated privileged-mode flag |
| taken | output | 1 | One-cycle pulse on each entry |
| code_err | output | 1 | One-cycle pulse for an undefined exception code |

## Verification
The assertions assume that every input is at a known value whenever reset is inactive. They also assume `pal_base` is wide enough for the base-plus-offset sum to be read without thought of wrap. The stimulus keeps to this by idling every input at zero between scenarios and by using small base values. Inputs are changed only at falling edges, so each sampled edge sees one stable scenario, and `taken` returns low between scenarios.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int unsigned NUM_IRQ = 4;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned OFF_W   = 14;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET   = 4'd0,
    EXC_MCHECK  = 4'd1,
    EXC_IPI     = 4'd2,
    EXC_TIMER   = 4'd3,
    EXC_DEVICE  = 4'd4,
    EXC_MEMFLT  = 4'd5,
    EXC_UNALIGN = 4'd6,
    EXC_ILLOP   = 4'd7,
    EXC_ARITH   = 4'd8,
    EXC_FPDIS   = 4'd9,
    EXC_PCALL   = 4'd10
  } exc_code_e;

  localparam logic [CODE_W-1:0] LAST_CODE = EXC_PCALL;
endpackage

// File: rtl/irq_select.sv
module irq_select
  import trap_entry_pkg::*;
#(
  parameter int unsigned IPL_W = 3
) (
  input  logic [NUM_IRQ-1:0] req,
  input  logic [IPL_W-1:0]   ipl,
  input  logic               priv,
  output logic [NUM_IRQ-1:0] grant,
  output logic [CODE_W-1:0]  code
);
  // Line k is eligible when ipl <= 3 + k (fixed fall-through thresholds).
  logic [NUM_IRQ-1:0] eligible;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_elig
    localparam int unsigned LIMIT = 3 + k;
    assign eligible[k] = req[k] && !priv && (int'(ipl) <= LIMIT);
  end

  // Highest index wins; code for line k is EXC_DEVICE - k.
  always_comb begin
    grant = '0;
    code  = EXC_RESET;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (eligible[k]) begin
        grant = '0;
        grant[k] = 1'b1;
        code = CODE_W'(int'(EXC_DEVICE) - k);
      end
    end
  end

  always_comb begin
    assert_one_grant_R3: assert ($onehot0(grant));
  end
endmodule

// File: rtl/entry_offset.sv
module entry_offset
  import trap_entry_pkg::*;
#(
  parameter int unsigned CALL_W = 8
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CALL_W-1:0] call_code,
  output logic [OFF_W-1:0]  offset,
  output logic              bad_code
);
  localparam logic [OFF_W-1:0] UNPRIV_BASE = OFF_W'(14'h2000);
  localparam logic [OFF_W-1:0] PRIV_BASE   = OFF_W'(14'h1000);
  localparam int unsigned      SLOT_SH     = 6;
  localparam int unsigned      VEC_SH      = 7;

  logic [CALL_W-2:0] call_idx;
  assign call_idx = call_code[CALL_W-2:0];

  always_comb begin
    bad_code = code > LAST_CODE;
    if (code == EXC_PCALL) begin
      offset = (call_code[CALL_W-1] ? UNPRIV_BASE : PRIV_BASE)
             + (OFF_W'(call_idx) << SLOT_SH);
    end else begin
      offset = OFF_W'(code) << VEC_SH;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned IPL_W  = 3,
  parameter int unsigned CALL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        irq_req,
  input  logic              exc_valid,
  input  logic [3:0]        exc_code,
  input  logic [CALL_W-1:0] call_code,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   pal_base,
  input  logic [IPL_W-1:0]  ipl,
  input  logic              priv_in,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   exc_addr,
  output logic              priv_out,
  output logic              taken,
  output logic              code_err
);
  logic [NUM_IRQ-1:0] irq_grant;
  logic [CODE_W-1:0]  irq_code;
  logic [CODE_W-1:0]  sel_code;
  logic [OFF_W-1:0]   offset;
  logic               bad_code;
  logic               enter;
  logic               raise_err;

  irq_select #(.IPL_W(IPL_W)) u_irq_select (
    .req   (irq_req),
    .ipl   (ipl),
    .priv  (priv_in),
    .grant (irq_grant),
    .code  (irq_code)
  );

  // Exception wins over interrupt (R8).
  assign sel_code = exc_valid ? exc_code : irq_code;

  entry_offset #(.CALL_W(CALL_W)) u_entry_offset (
    .code      (sel_code),
    .call_code (call_code),
    .offset    (offset),
    .bad_code  (bad_code)
  );

  assign raise_err = exc_valid && bad_code;
  assign enter     = exc_valid ? !bad_code : (irq_grant != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_pc   <= '0;
      exc_addr <= '0;
      priv_out <= 1'b0;
      taken    <= 1'b0;
      code_err <= 1'b0;
    end else begin
      taken    <= enter;
      code_err <= raise_err;
      if (enter) begin
        new_pc   <= pal_base + XLEN'(offset);
        exc_addr <= {pc_in[XLEN-1:1], pc_in[0] | priv_in};
        priv_out <= 1'b1;
      end
    end
  end

  assert_priv_on_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> priv_out);

  assert_no_irq_in_priv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && priv_in) |=> !taken);

  assert_device_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_grant[0] |-> (ipl <= 3'd3));

  assert_exc_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (exc_addr[XLEN-1:1] == $past(pc_in[XLEN-1:1])));

  assert_err_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> (!taken && $stable(new_pc) && $stable(exc_addr) && $stable(priv_out)));

  assert_exc_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !bad_code) |=> (new_pc == $past(pal_base) + XLEN'($past(offset))));
endmodule

// File: tb/test_trap_entry_ctrl.sv
`timescale 1ns/1ps
module test_trap_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_req = '0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [7:0]  call_code = '0;
  logic [63:0] pc_in = '0;
  logic [63:0] pal_base = '0;
  logic [2:0]  ipl = '0;
  logic        priv_in = 1'b0;
  logic [63:0] new_pc, exc_addr;
  logic        priv_out, taken, code_err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trap_entry_ctrl i_trap_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .exc_valid(exc_valid),
    .exc_code(exc_code), .call_code(call_code), .pc_in(pc_in),
    .pal_base(pal_base), .ipl(ipl), .priv_in(priv_in), .new_pc(new_pc),
    .exc_addr(exc_addr), .priv_out(priv_out), .taken(taken), .code_err(code_err)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Apply one scenario at a falling edge, let one rising edge sample it,
  // then idle inputs and return at the following falling edge.
  task automatic apply(logic [3:0] irq, logic ev, logic [3:0] code, logic [7:0] cc,
                       logic [63:0] pc, logic [63:0] base, logic [2:0] lvl, logic pr);
    @(negedge clk);
    irq_req = irq; exc_valid = ev; exc_code = code; call_code = cc;
    pc_in = pc; pal_base = base; ipl = lvl; priv_in = pr;
    @(negedge clk);
    irq_req = '0; exc_valid = 1'b0; exc_code = '0; call_code = '0; priv_in = 1'b0;
  endtask

  function automatic logic [63:0] pcall_off(logic [7:0] c);
    if (c[7]) return 64'h2000 + (64'(c) - 64'h80) * 64;
    return 64'h1000 + 64'(c) * 64;
  endfunction

  task automatic t_reset();
    check("R10", "new_pc", new_pc, 0);
    check("R10", "exc_addr", exc_addr, 0);
    check("R10", "priv_out", priv_out, 0);
    check("R10", "taken", taken, 0);
    check("R10", "code_err", code_err, 0);
  endtask

  task automatic t_exceptions();
    for (int c = 0; c < 10; c++) begin
      apply(4'h0, 1'b1, 4'(c), 8'h00, 64'h4000 + c * 16, 64'h10000, 3'd7, 1'b0);
      check("R4", "new_pc", new_pc, 64'h10000 + 64'(c) * 64'h80);
      check("R7", "taken", taken, 1);
      check("R7", "priv_out", priv_out, 1);
    end
    @(negedge clk);
    check("R7", "taken pulse ends", taken, 0);
    check("R7", "new_pc held", new_pc, 64'h10000 + 64'h480);
  endtask

  task automatic t_pcall();
    logic [7:0] codes [4] = '{8'h00, 8'h3F, 8'h80, 8'hBF};
    for (int i = 0; i < 4; i++) begin
      apply(4'h0, 1'b1, 4'd10, codes[i], 64'h800, 64'h20000, 3'd0, 1'b0);
      check("R5", "pcall new_pc", new_pc, 64'h20000 + pcall_off(codes[i]));
    end
  endtask

  task automatic t_saved_addr();
    apply(4'h0, 1'b1, 4'd5, 8'h0, 64'h1234_5678, 64'h0, 3'd0, 1'b1);
    check("R6", "exc_addr priv", exc_addr, 64'h1234_5679);
    apply(4'h0, 1'b1, 4'd6, 8'h0, 64'hABCD_0000, 64'h0, 3'd0, 1'b0);
    check("R6", "exc_addr user", exc_addr, 64'hABCD_0000);
  endtask

  task automatic t_ipl_mask();
    for (int lvl = 0; lvl < 8; lvl++) begin
      for (int k = 0; k < 4; k++) begin
        logic [63:0] prev = new_pc;
        bit elig = (lvl <= 3 + k);
        apply(4'(1 << k), 1'b0, 4'd0, 8'h0, 64'h100, 64'h40000 + 64'(lvl), 3'(lvl), 1'b0);
        check("R2", "taken vs ipl", taken, elig);
        check("R2", "new_pc vs ipl", new_pc,
              elig ? 64'h40000 + 64'(lvl) + 64'(4 - k) * 64'h80 : prev);
      end
    end
  endtask

  task automatic t_priority();
    apply(4'hF, 1'b0, 4'd0, 8'h0, 64'h0, 64'h50000, 3'd0, 1'b0);
    check("R3", "all pending -> mcheck", new_pc, 64'h50080);
    apply(4'h7, 1'b0, 4'd0, 8'h0, 64'h0, 64'h50000, 3'd0, 1'b0);
    check("R3", "ipi over timer", new_pc, 64'h50100);
    apply(4'h3, 1'b0, 4'd0, 8'h0, 64'h0, 64'h50000, 3'd0, 1'b0);
    check("R3", "timer over device", new_pc, 64'h50180);
    apply(4'hF, 1'b0, 4'd0, 8'h0, 64'h0, 64'h50000, 3'd6, 1'b0);
    check("R3", "ipl6 leaves mcheck", new_pc, 64'h50080);
  endtask

  task automatic t_priv_block();
    logic [63:0] prev = new_pc;
    apply(4'hF, 1'b0, 4'd0, 8'h0, 64'h0, 64'h60000, 3'd0, 1'b1);
    check("R1", "irq in priv taken", taken, 0);
    check("R1", "irq in priv new_pc", new_pc, prev);
    apply(4'hF, 1'b1, 4'd8, 8'h0, 64'h0, 64'h60000, 3'd0, 1'b1);
    check("R1", "exc in priv", new_pc, 64'h60400);
  endtask

  task automatic t_exc_first();
    apply(4'hF, 1'b1, 4'd7, 8'h0, 64'h0, 64'h70000, 3'd0, 1'b0);
    check("R8", "exception over irq", new_pc, 64'h70380);
  endtask

  task automatic t_bad_code();
    logic [63:0] pnpc = new_pc;
    logic [63:0] pea = exc_addr;
    apply(4'hF, 1'b1, 4'd11, 8'h0, 64'hFFF0, 64'h80000, 3'd0, 1'b0);
    check("R9", "code_err", code_err, 1);
    check("R9", "taken", taken, 0);
    check("R9", "new_pc held", new_pc, pnpc);
    check("R9", "exc_addr held", exc_addr, pea);
    apply(4'h0, 1'b1, 4'd15, 8'h0, 64'hFFF0, 64'h80000, 3'd0, 1'b0);
    check("R9", "code 15 err", code_err, 1);
    @(negedge clk);
    check("R9", "err pulse ends", code_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exceptions();
    t_pcall();
    t_saved_addr();
    t_ipl_mask();
    t_priority();
    t_priv_block();
    t_exc_first();
    t_bad_code();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule